// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one bidirectional port of a small microcontroller. A simple synchronous register bus writes and reads three addresses. One holds the per-pin configuration bits and one holds the per-pin output data bits. The third is read-only and returns the synchronized pin levels. Each pin is set up on its own from its configuration/data bit pair. The pair selects one of four modes: high-impedance input, input with weak pull-up, driven low, or driven high. The block presents the resulting drive-enable, drive-value and pull-up-enable signals to the pad ring as registered outputs.

A parameter selects a special variant of the port. In that variant, the top two bit positions carry fixed functions instead of general-purpose I/O. Bit 6 is an input-only pin and bit 7 is a dedicated clock-output pin. Their register bits are not stored. Writing the data register with bit 7 set raises a one-cycle HALT request. Writing it with bit 6 set raises a one-cycle IDLE request. The clock gating and power control that act on these requests sit outside this block.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high, and after it falls, the configuration and data registers hold zero and `bus_rdata` is zero. `pin_oe`, `pin_out`, `pin_pu`, `halt_req` and `idle_req` are low, so every pin starts as a high-impedance input.
- R2: Address 0 is the configuration register and address 1 is the data register. Address 2 returns the synchronized pin levels and ignores writes. Address 3 reads zero. `bus_rdata` is registered: at each clock edge it captures the content at `bus_addr`, taking register values from before any write on that same edge.
- R3: A pin whose configuration bit is 0 and data bit is 0 has `pin_oe`=0 and `pin_pu`=0.
- R4: A pin whose configuration bit is 0 and data bit is 1 has `pin_pu`=1 and `pin_oe`=0. `pin_oe` and `pin_pu` are never both 1 on a pin.
- R5: A pin whose configuration bit is 1 has `pin_oe`=1, `pin_pu`=0 and `pin_out` equal to its data bit. `pin_out` is 0 whenever `pin_oe` is 0. The pin outputs follow a register write one clock edge after the edge that stores it.
- R6: Each pin's mode depends only on its own configuration and data bits. A write changes each pin exactly as its own bit pair dictates.
- R7: `pin_in` passes through a two-stage synchronizer. A level present at edge k appears in the data that `bus_rdata` captures at edge k+2 when address 2 is selected.
- R8: With `SPECIAL`=1, configuration and data bits 6 and 7 are not stored and read back as zero. `pin_oe`, `pin_out` and `pin_pu` bits 6 and 7 stay 0. Bits 0 to 5 behave as in R3 to R6.
- R9: With `SPECIAL`=1, a write to address 1 with bit 7 set makes `halt_req` high for exactly the cycle after that edge.
- R10: With `SPECIAL`=1, a write to address 1 with bit 6 set and bit 7 clear makes `idle_req` high for exactly the cycle after that edge.
- R11: A write with both bit 6 and bit 7 set raises only `halt_req`. `halt_req` and `idle_req` are never high together.
- R12: With `SPECIAL`=0, all eight bits are general-purpose I/O stored and read back in full, and `halt_req` and `idle_req` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address (0 config, 1 data, 2 pins, 3 reserved) |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data for the address of the previous cycle |
| pin_in | input | WIDTH | Raw pad input levels |
| pin_oe | output | WIDTH | Per-pin push-pull drive enable |
| pin_out | output | WIDTH | Per-pin drive value |
| pin_pu | output | WIDTH | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle HALT request (special variant) |
| idle_req | output | 1 | One-cycle IDLE request (special variant) |

## Verification
The bench drives a special and a standard instance with the same stimulus and compares both against a behavioural model on every clock. The stimulus includes all four mode pairs mixed across bits, writes to the read-only pin address, and reads of the reserved address. A design that stored the write to address 2, or decoded address 3 as an alias, would return a wrong read-back. Writes with bit 6 only, bit 7 only, both bits, and back-to-back writes probe the request pulses. A wrong priority would show both requests together, and a stored request bit would stretch the pulse or leak into the read-back of data bits 6 and 7. Pin levels change one cycle apart during reads of address 2, which exposes a synchronizer one stage short or long, and a random phase covers ordinary traffic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CFG  = 2'd0,
    ADR_DAT  = 2'd1,
    ADR_PIN  = 2'd2,
    ADR_RSVD = 2'd3
  } port_addr_e;

  // Per-pin mode derived from a configuration/data bit pair
  typedef enum logic [1:0] {
    MODE_HIZ   = 2'b00,
    MODE_PULL  = 2'b01,
    MODE_DRV0  = 2'b10,
    MODE_DRV1  = 2'b11
  } pin_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];
  logic             live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_async;
        end
        p_sync_first_r7: assert property (@(posedge clk) disable iff (rst)
          live |-> chain[0] == $past(d_async));
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
        p_sync_shift_r7: assert property (@(posedge clk) disable iff (rst)
          live |-> chain[s] == $past(chain[s-1]));
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter bit               SPECIAL  = 1'b1,
  parameter int               HALT_BIT = 7,
  parameter int               IDLE_BIT = 6,
  parameter logic [WIDTH-1:0] GP_MASK  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  port_addr_e       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] cfg_q,
  output logic [WIDTH-1:0] dat_q,
  output logic             halt_req,
  output logic             idle_req
);

  logic wr_cfg, wr_dat;
  logic halt_hit, idle_hit;

  assign wr_cfg = we && (addr == ADR_CFG);
  assign wr_dat = we && (addr == ADR_DAT);

  // Only general-purpose bits are stored; fixed-function bits stay zero
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wdata & GP_MASK;
      if (wr_dat) dat_q <= wdata & GP_MASK;
    end
  end

  generate
    if (SPECIAL) begin : g_req
      assign halt_hit = wr_dat && wdata[HALT_BIT];
      assign idle_hit = wr_dat && wdata[IDLE_BIT] && !wdata[HALT_BIT];
    end else begin : g_noreq
      assign halt_hit = 1'b0;
      assign idle_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req <= 1'b0;
      idle_req <= 1'b0;
    end else begin
      halt_req <= halt_hit;
      idle_req <= idle_hit;
    end
  end

  p_req_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && idle_req));

  p_halt_src_r9: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> $past(we && addr == ADR_DAT && wdata[HALT_BIT]));

  p_idle_src_r10: assert property (@(posedge clk) disable iff (rst)
    idle_req |-> $past(we && addr == ADR_DAT && wdata[IDLE_BIT] && !wdata[HALT_BIT]));

  generate
    if (!SPECIAL) begin : g_std_chk
      p_std_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !halt_req && !idle_req);
    end
  endgenerate

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] GP_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cfg_q,
  input  logic [WIDTH-1:0] dat_q,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (GP_MASK[i]) begin : g_gp
        pin_mode_e mode;
        assign mode = pin_mode_e'({cfg_q[i], dat_q[i]});
        always_ff @(posedge clk) begin
          if (rst) begin
            pin_oe[i]  <= 1'b0;
            pin_out[i] <= 1'b0;
            pin_pu[i]  <= 1'b0;
          end else begin
            pin_oe[i]  <= (mode == MODE_DRV0) || (mode == MODE_DRV1);
            pin_out[i] <= (mode == MODE_DRV1);
            pin_pu[i]  <= (mode == MODE_PULL);
          end
        end
      end else begin : g_fixed
        // Fixed-function position: never driven or pulled by this block
        assign pin_oe[i]  = 1'b0;
        assign pin_out[i] = 1'b0;
        assign pin_pu[i]  = 1'b0;
      end
    end
  endgenerate

  p_oe_pu_excl_r4: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & pin_pu) == '0);

  p_out_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  p_fixed_idle_r8: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe | pin_out | pin_pu) & ~GP_MASK) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit SPECIAL     = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int HALT_BIT    = 7,
  parameter int IDLE_BIT    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_pu,
  output logic              halt_req,
  output logic              idle_req
);

  localparam logic [WIDTH-1:0] ONE_HOT_H = WIDTH'(1) << HALT_BIT;
  localparam logic [WIDTH-1:0] ONE_HOT_I = WIDTH'(1) << IDLE_BIT;
  localparam logic [WIDTH-1:0] GP_MASK   = SPECIAL ? ~(ONE_HOT_H | ONE_HOT_I) : '1;

  port_addr_e       addr;
  logic [WIDTH-1:0] cfg_q, dat_q, pins_q;

  assign addr = port_addr_e'(bus_addr);

  gpio_regs #(
    .WIDTH(WIDTH), .SPECIAL(SPECIAL), .HALT_BIT(HALT_BIT),
    .IDLE_BIT(IDLE_BIT), .GP_MASK(GP_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(addr), .wdata(bus_wdata),
    .cfg_q(cfg_q), .dat_q(dat_q), .halt_req(halt_req), .idle_req(idle_req)
  );

  gpio_pin_ctrl #(
    .WIDTH(WIDTH), .GP_MASK(GP_MASK)
  ) u_pins (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .dat_q(dat_q),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  gpio_sync #(
    .WIDTH(WIDTH), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .q_sync(pins_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (addr)
        ADR_CFG:  bus_rdata <= cfg_q;
        ADR_DAT:  bus_rdata <= dat_q;
        ADR_PIN:  bus_rdata <= pins_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == ADR_RSVD |-> bus_rdata == '0);

  p_fixed_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADR_CFG || $past(bus_addr) == ADR_DAT)
      |-> (bus_rdata & ~GP_MASK) == '0);

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] pin_in = '0;

  logic [7:0] rd_s, oe_s, out_s, pu_s, rd_g, oe_g, out_g, pu_g;
  logic       halt_s, idle_s, halt_g, idle_g;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.WIDTH(8), .SPECIAL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_s), .pin_in(pin_in), .pin_oe(oe_s), .pin_out(out_s), .pin_pu(pu_s),
    .halt_req(halt_s), .idle_req(idle_s));

  gpio_port #(.WIDTH(8), .SPECIAL(1'b0)) u_dut_std (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_g), .pin_in(pin_in), .pin_oe(oe_g), .pin_out(out_g), .pin_pu(pu_g),
    .halt_req(halt_g), .idle_req(idle_g));

  // Reference model state, index 0 = special variant, 1 = standard variant
  int    n_cmp = 0, n_bad = 0;
  bit    armed = 0;
  string cur_req = "R1";
  int    m_cfg[2], m_dat[2], m_s1, m_s2;
  int    e_rd[2], e_oe[2], e_out[2], e_pu[2], e_h[2], e_i[2];

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("spc rdata(R2)", rd_s, e_rd[0]);  chk("std rdata(R2)", rd_g, e_rd[1]);
    chk("spc oe(R5)", oe_s, e_oe[0]);     chk("std oe(R5)", oe_g, e_oe[1]);
    chk("spc out(R5)", out_s, e_out[0]);  chk("std out(R5)", out_g, e_out[1]);
    chk("spc pu(R4)", pu_s, e_pu[0]);     chk("std pu(R4)", pu_g, e_pu[1]);
    chk("spc halt(R9)", halt_s, e_h[0]);  chk("std halt(R12)", halt_g, e_h[1]);
    chk("spc idle(R10)", idle_s, e_i[0]); chk("std idle(R12)", idle_g, e_i[1]);
  endtask

  task automatic model_step(bit r, bit we, int a, int wd, int pins);
    for (int v = 0; v < 2; v++) begin
      int mk = (v == 0) ? 'h3F : 'hFF;
      if (r) begin
        m_cfg[v] = 0; m_dat[v] = 0;
        e_rd[v] = 0; e_oe[v] = 0; e_out[v] = 0; e_pu[v] = 0; e_h[v] = 0; e_i[v] = 0;
      end else begin
        case (a)
          0: e_rd[v] = m_cfg[v];
          1: e_rd[v] = m_dat[v];
          2: e_rd[v] = m_s2;
          default: e_rd[v] = 0;
        endcase
        e_oe[v]  = m_cfg[v];
        e_out[v] = m_cfg[v] & m_dat[v];
        e_pu[v]  = ~m_cfg[v] & m_dat[v] & 'hFF;
        e_h[v] = (v == 0 && we && a == 1 && wd[7]) ? 1 : 0;
        e_i[v] = (v == 0 && we && a == 1 && wd[6] && !wd[7]) ? 1 : 0;
        if (we && a == 0) m_cfg[v] = wd & mk;
        if (we && a == 1) m_dat[v] = wd & mk;
      end
    end
    if (r) begin m_s1 = 0; m_s2 = 0; end
    else   begin m_s2 = m_s1; m_s1 = pins; end
  endtask

  task automatic step(bit r, bit we, int a, int wd, int pins);
    @(negedge clk);
    if (armed) compare_all();
    rst = r; bus_we = we; bus_addr = 2'(a); bus_wdata = 8'(wd); pin_in = 8'(pins);
    @(posedge clk);
    model_step(r, we, a, wd & 'hFF, pins & 'hFF);
    if (r) armed = 1;
  endtask

  task automatic wr(int a, int wd); step(0, 1, a, wd, pin_in); endtask
  task automatic rd(int a);         step(0, 0, a, 0, pin_in);  endtask

  initial begin
    int lfsr = 'hACE1;
    // R1: reset state
    cur_req = "R1";
    repeat (3) step(1, 0, 0, 0, 0);
    repeat (3) rd(0);
    // R3 R4 R5 R6: mixed mode pairs across bits
    cur_req = "R3";
    wr(0, 'h00); wr(1, 'h00); rd(1); rd(1);
    cur_req = "R4";
    wr(1, 'hFF); rd(0); rd(1);
    cur_req = "R5";
    wr(0, 'hF0); wr(1, 'hA5); rd(0); rd(1);
    cur_req = "R6";
    wr(0, 'h3C); rd(1); wr(1, 'h69); rd(0); wr(0, 'hC3); rd(1); rd(1);
    // R2: pin address ignores writes; reserved reads zero
    cur_req = "R2";
    wr(2, 'hFF); rd(0); rd(1); rd(2); wr(3, 'h55); rd(3); rd(0);
    // R7: synchronizer latency on the read path
    cur_req = "R7";
    step(0, 0, 2, 0, 'h5A); step(0, 0, 2, 0, 'hA5); step(0, 0, 2, 0, 'h0F);
    step(0, 0, 2, 0, 'hF0); step(0, 0, 2, 0, 'hF0); step(0, 0, 2, 0, 'hF0);
    // R8: fixed-function bits not stored in the special variant
    cur_req = "R8";
    wr(0, 'hFF); wr(1, 'h3F); rd(0); rd(1); wr(0, 'hC0); rd(0);
    // R9 R10 R11: request pulses, priority, back-to-back
    cur_req = "R9";
    wr(1, 'h80); rd(1); rd(1); wr(1, 'h81); wr(1, 'h80); rd(1);
    cur_req = "R10";
    wr(1, 'h40); rd(1); rd(1); wr(1, 'h42); rd(1);
    cur_req = "R11";
    wr(1, 'hC0); rd(1); wr(1, 'hC0); wr(1, 'h40); wr(1, 'h80); rd(1);
    // R12: standard variant exercised in parallel on every cycle; random traffic
    cur_req = "R12";
    for (int k = 0; k < 400; k++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      step(0, lfsr[0], (lfsr >> 1) & 3, (lfsr >> 4) & 'hFF, (lfsr >> 8) & 'hFF);
    end
    cur_req = "R1";
    step(1, 1, 1, 'hFF, 'hFF); step(1, 0, 0, 0, 0); rd(0); rd(1); rd(2);
    @(negedge clk); compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule